// File: doc/BRIEF.md
# Parallel LCD Write-Cycle Sequencer

This block carries out one 8080-style parallel write to an LCD panel for each command it accepts. A command brings an address word, a data word and four phase lengths. Each phase length is measured in cycles of the internal video clock. The sequencer first puts the address on the panel bus. It then pulls chip select low, then pulls write enable low, and releases the two strobes in the reverse order. Each of the four gaps lasts the programmed value plus one cycle.

The data word is driven, with an output-enable flag, from the cycle in which write enable falls until chip select rises. A one-cycle completion pulse marks the return of chip select. A timing-select input picks between the programmed phase fields and a fixed default set. Every command field is latched at acceptance, so the register inputs may change freely while a write is under way.

Top module: `lcd_wcycle_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `lcd_cs_n` and `lcd_we_n` are 1, `cmd_ready` is 1, `done` is 0, `lcd_data_oe` is 0 and `lcd_data` is 0.
- R2: A command is taken only on a rising clock edge where both `cmd_valid` and `cmd_ready` are 1. A `cmd_valid` that is raised while `cmd_ready` is 0 starts no write: `lcd_cs_n` stays 1 after the current write ends.
- R3: From the edge that accepts a command, `lcd_addr` shows the accepted address. It keeps that value at least until `lcd_cs_n` has returned to 1.
- R4: `lcd_cs_n` goes to 0 exactly S+1 cycles after the accepting edge, where S is the chip-select setup value.
- R5: `lcd_we_n` goes to 0 exactly P+1 cycles after `lcd_cs_n` falls, where P is the write setup value.
- R6: `lcd_we_n` stays 0 for exactly A+1 cycles, where A is the write active value, and then returns to 1. It is 0 only while `lcd_cs_n` is 0.
- R7: `lcd_cs_n` returns to 1 exactly H+1 cycles after `lcd_we_n` rises, where H is the write hold value.
- R8: `lcd_data_oe` is 1, and `lcd_data` equals the accepted data word, from the cycle in which `lcd_we_n` falls up to the cycle before `lcd_cs_n` rises. At all other times `lcd_data_oe` is 0 and `lcd_data` is 0.
- R9: When `tim_override` is 0 at acceptance, the phase values used are S=0, P=0, A=1 and H=0, whatever the four phase inputs hold. When it is 1, the four 4-bit unsigned inputs are used.
- R10: A change to the address, data, phase or `tim_override` inputs after acceptance has no effect on the write in progress.
- R11: `cmd_ready` falls at the accepting edge and rises again at the same edge where `lcd_cs_n` returns to 1.
- R12: `done` is 1 for exactly the one cycle that starts at the edge where `lcd_cs_n` returns to 1, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal video clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle; a command is taken when both are high |
| cmd_addr | input | ADDR_W | Address word of the command |
| cmd_data | input | DATA_W | Data word of the command |
| tim_override | input | 1 | 1 = use the phase inputs, 0 = use the defaults |
| tim_cs_setup | input | 4 | Address-to-chip-select gap minus one |
| tim_wr_setup | input | 4 | Chip-select-to-write gap minus one |
| tim_wr_active | input | 4 | Write strobe width minus one |
| tim_wr_hold | input | 4 | Write-release-to-chip-select-release gap minus one |
| lcd_addr | output | ADDR_W | Panel address bus |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_we_n | output | 1 | Write enable, active low |
| lcd_data | output | DATA_W | Panel data bus, 0 when not driven |
| lcd_data_oe | output | 1 | Data bus drive enable |
| done | output | 1 | One-cycle write completion pulse |

## Verification
The bench rebuilds each write cycle by cycle from the four phase lengths. It compares every strobe, the bus and the handshake outputs against that rebuilt waveform. Phase values of zero and of fifteen catch any off-by-one in the plus-one stretch, which would show as a strobe edge one cycle early or late. Mid-write changes to the inputs, and commands offered while busy, catch a design that reads live inputs or accepts a second command; such a design would show a shifted edge, a changed address or an extra chip-select pulse. Writes with the timing select low catch a design that ignores the default set, which would show the programmed lengths instead of a two-cycle write strobe.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int PHASE_W = 4;
  localparam int LEN_W   = PHASE_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } wcs_state_e;

  typedef struct packed {
    logic [PHASE_W-1:0] cs_setup;
    logic [PHASE_W-1:0] wr_setup;
    logic [PHASE_W-1:0] wr_active;
    logic [PHASE_W-1:0] wr_hold;
  } wcs_timing_t;

  function automatic wcs_timing_t dflt_timing();
    wcs_timing_t t;
    t.cs_setup  = '0;
    t.wr_setup  = '0;
    t.wr_active = PHASE_W'(1);
    t.wr_hold   = '0;
    return t;
  endfunction

  function automatic logic [LEN_W-1:0] phase_cycles(input logic [PHASE_W-1:0] v);
    return LEN_W'(v) + LEN_W'(1);
  endfunction

  function automatic wcs_timing_t pick_timing(input logic use_prog, input wcs_timing_t prog);
    return use_prog ? prog : dflt_timing();
  endfunction
endpackage

// File: rtl/wcs_phase_timer.sv
module wcs_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);

  p_timer_descends_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/wcs_capture.sv
module wcs_capture
  import wcs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  wcs_timing_t       tim_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output wcs_timing_t       tim_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      tim_q  <= dflt_timing();
    end else if (take) begin
      addr_q <= addr_in;
      data_q <= data_in;
      tim_q  <= tim_in;
    end
  end

  p_hold_fields_r10: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(addr_q) && $stable(data_q) && $stable(tim_q)));
endmodule

// File: rtl/wcs_ctrl.sv
module wcs_ctrl
  import wcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  wcs_timing_t        tim_new,
  input  wcs_timing_t        tim_cur,
  input  logic               phase_over,
  output logic               tmr_load,
  output logic [PHASE_W-1:0] tmr_val,
  output wcs_state_e         state,
  output logic               done
);
  wcs_state_e state_d;
  logic       leave_phase;
  logic       last_phase;

  assign leave_phase = (state != ST_IDLE) && phase_over;
  assign last_phase  = (state == ST_HOLD) && phase_over;

  always_comb begin
    state_d  = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        state_d  = ST_ADDR;
        tmr_load = 1'b1;
        tmr_val  = tim_new.cs_setup;
      end
      ST_ADDR: if (leave_phase) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = tim_cur.wr_setup;
      end
      ST_SETUP: if (leave_phase) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = tim_cur.wr_active;
      end
      ST_STROBE: if (leave_phase) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = tim_cur.wr_hold;
      end
      ST_HOLD: if (leave_phase) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= last_phase;
    end
  end

  p_idle_only_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !accept) |=> (state == ST_IDLE));
  p_done_after_hold_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(state) == ST_HOLD && state == ST_IDLE));
endmodule

// File: rtl/wcs_pins.sv
module wcs_pins
  import wcs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  wcs_state_e        state,
  input  logic [DATA_W-1:0] data_q,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe,
  output logic [DATA_W-1:0] data_out
);
  logic in_select;
  logic in_write;

  assign in_select = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign in_write  = (state == ST_STROBE) || (state == ST_HOLD);

  assign cs_n     = !in_select;
  assign we_n     = (state != ST_STROBE);
  assign oe       = in_write;
  assign data_out = in_write ? data_q : '0;

  p_we_inside_cs_r6: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !cs_n);
  p_oe_inside_cs_r8: assert property (@(posedge clk) disable iff (rst)
    oe |-> !cs_n);
  p_we_rise_cs_low_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (!cs_n && oe));
endmodule

// File: rtl/lcd_wcycle_seq.sv
module lcd_wcycle_seq
  import wcs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_data,
  input  logic               tim_override,
  input  logic [PHASE_W-1:0] tim_cs_setup,
  input  logic [PHASE_W-1:0] tim_wr_setup,
  input  logic [PHASE_W-1:0] tim_wr_active,
  input  logic [PHASE_W-1:0] tim_wr_hold,
  output logic [ADDR_W-1:0]  lcd_addr,
  output logic               lcd_cs_n,
  output logic               lcd_we_n,
  output logic [DATA_W-1:0]  lcd_data,
  output logic               lcd_data_oe,
  output logic               done
);
  wcs_state_e         state;
  wcs_timing_t        tim_prog, tim_eff, tim_q;
  logic               accept;
  logic               tmr_load, tmr_expired;
  logic [PHASE_W-1:0] tmr_val;
  logic [DATA_W-1:0]  data_q;

  assign tim_prog = '{cs_setup: tim_cs_setup, wr_setup: tim_wr_setup,
                      wr_active: tim_wr_active, wr_hold: tim_wr_hold};
  assign tim_eff   = pick_timing(tim_override, tim_prog);
  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  wcs_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .take(accept),
    .addr_in(cmd_addr), .data_in(cmd_data), .tim_in(tim_eff),
    .addr_q(lcd_addr), .data_q(data_q), .tim_q(tim_q)
  );

  wcs_phase_timer #(.W(PHASE_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  wcs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .tim_new(tim_eff),
    .tim_cur(tim_q), .phase_over(tmr_expired), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .state(state), .done(done)
  );

  wcs_pins #(.DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .state(state), .data_q(data_q),
    .cs_n(lcd_cs_n), .we_n(lcd_we_n), .oe(lcd_data_oe), .data_out(lcd_data)
  );

  p_done_on_cs_rise_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_cs_n) |-> (done && cmd_ready));
  p_ready_falls_on_accept_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_ready) |-> $past(cmd_valid));
  p_addr_steady_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ready && $past(!cmd_ready)) |-> $stable(lcd_addr));
  p_cs_falls_from_idle_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_cs_n) |-> (lcd_we_n && !cmd_ready));
endmodule

// File: tb/sim_lcd_wcycle_seq.sv
module sim_lcd_wcycle_seq;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic tim_override = 1'b0;
  logic [3:0] t_cs = '0, t_ws = '0, t_wa = '0, t_wh = '0;
  logic [AW-1:0] lcd_addr;
  logic lcd_cs_n, lcd_we_n, lcd_data_oe, done;
  logic [DW-1:0] lcd_data;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lcd_wcycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .tim_override(tim_override),
    .tim_cs_setup(t_cs), .tim_wr_setup(t_ws), .tim_wr_active(t_wa),
    .tim_wr_hold(t_wh), .lcd_addr(lcd_addr), .lcd_cs_n(lcd_cs_n),
    .lcd_we_n(lcd_we_n), .lcd_data(lcd_data), .lcd_data_oe(lcd_data_oe),
    .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int eff_len(input logic ovr, input logic [3:0] v, input int dflt);
    return ovr ? int'(v) + 1 : dflt + 1;
  endfunction

  task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic ovr, input logic [3:0] c, input logic [3:0] s,
                           input logic [3:0] w, input logic [3:0] h,
                           input bit disturb);
    int la, lb, lw, lh, tend;
    bit exp_cs_n, exp_we_n, exp_oe;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d; tim_override = ovr;
    t_cs = c; t_ws = s; t_wa = w; t_wh = h;
    la = eff_len(ovr, c, 0);
    lb = eff_len(ovr, s, 0);
    lw = eff_len(ovr, w, 1);
    lh = eff_len(ovr, h, 0);
    tend = la + lb + lw + lh;
    for (int k = 0; k <= tend + 1; k++) begin
      @(negedge clk);
      exp_cs_n = !(k >= la && k < tend);
      exp_we_n = !(k >= la + lb && k < la + lb + lw);
      exp_oe   = (k >= la + lb && k < tend);
      chk(disturb ? "R10" : "R4", "cs_n", lcd_cs_n, exp_cs_n);
      if (k >= la + lb + lw) chk("R7", "cs_n after write", lcd_cs_n, exp_cs_n);
      chk(ovr ? "R5" : "R9", "we_n", lcd_we_n, exp_we_n);
      if (k >= la + lb) chk("R6", "we_n width", lcd_we_n, exp_we_n);
      chk("R8", "data_oe", lcd_data_oe, exp_oe);
      chk("R8", "data", lcd_data, exp_oe ? d : '0);
      chk("R11", "ready", cmd_ready, k >= tend);
      chk("R12", "done", done, k == tend);
      if (k <= tend) chk("R3", "addr", lcd_addr, a);
      if (k == tend + 1) chk("R2", "no extra write", lcd_cs_n, 1'b1);
      if (k < tend - 1 && disturb) begin
        cmd_valid = 1'b1;
        cmd_addr = $urandom; cmd_data = $urandom; tim_override = $urandom;
        t_cs = $urandom; t_ws = $urandom; t_wa = $urandom; t_wh = $urandom;
      end else begin
        cmd_valid = 1'b0;
      end
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "cs_n in reset", lcd_cs_n, 1);
    chk("R1", "we_n in reset", lcd_we_n, 1);
    chk("R1", "ready in reset", cmd_ready, 1);
    chk("R1", "done in reset", done, 0);
    chk("R1", "oe in reset", lcd_data_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "cs_n after reset", lcd_cs_n, 1);
    chk("R1", "data after reset", lcd_data, 0);
    // directed corners
    run_write(8'h11, 16'hA5A5, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0);
    run_write(8'hEE, 16'h5A5A, 1'b1, 4'd15, 4'd15, 4'd15, 4'd15, 1'b0);
    run_write(8'h3C, 16'h1234, 1'b0, 4'd9, 4'd7, 4'd5, 4'd3, 1'b0);
    run_write(8'hC3, 16'hFFFF, 1'b1, 4'd2, 4'd0, 4'd3, 4'd1, 1'b1);
    run_write(8'h77, 16'h0001, 1'b0, 4'd15, 4'd15, 4'd15, 4'd15, 1'b1);
    // random
    for (int i = 0; i < 60; i++) begin
      run_write(AW'($urandom), DW'($urandom), 1'($urandom_range(0, 3) != 0),
                4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                1'($urandom_range(0, 1)));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule